// File: doc/BRIEF.md
# Interrupt Delegation Selector

This block decides, once per clock, whether an interrupt should be taken, which one, and which privilege level handles it. Its inputs are the pending, enable and delegation vectors of the interrupt sources, the machine-level and supervisor-level global enable bits, and the hart's current privilege. The pending-and-enabled sources are split into two groups. One group stays with machine mode. The other group, made of the delegated sources, goes to supervisor mode.

The machine group is examined first. The supervisor group is examined only when the machine group does not apply, and only while the hart runs below machine level. A fixed priority picker then selects one source from the group that applies. The outputs are a take flag, a cause code and a target privilege, all registered. When nothing is taken, a set of debug outputs explains why. They show a reason code, both group masks, the global enable bits, and the machine timer source's pending, enable and delegate bits.

There is no data stream in or out. Every pin is a plain level signal sampled on each rising edge, so no valid/ready handshake and no back-pressure are involved.

Top module: `irq_deleg_select`

## Requirements
- R1: The machine group is `pend_i & enbl_i & ~deleg_i`. It applies when `m_gie_i` is 1 and the group is nonzero. An interrupt picked from it gives `take_o`=1 and `target_o`=3 (machine).
- R2: The supervisor group is `pend_i & enbl_i & deleg_i`. It applies when `s_gie_i` is 1, the group is nonzero, and `priv_i` is 0 (user) or 1 (supervisor). An interrupt picked from it gives `take_o`=1 and `target_o`=1 (supervisor).
- R3: When the machine group applies, the supervisor group is ignored. This holds even when the machine picker finds nothing.
- R4: A source's bit position equals its cause code. Within a group, the winner is the first present source in this order: 11, 3, 7, 9, 1, 5. The winner's code appears on `cause_o`.
- R5: When neither group applies, `take_o`=0, `cause_o`=0, `target_o`=0 and `reason_o`=0. When an interrupt is taken, `reason_o`=3.
- R6: When a group applies but holds none of the six standard bits, nothing is taken. `reason_o` is 1 if this happens in the machine group and 2 if it happens in the supervisor group.
- R7: While nothing is taken, the debug outputs carry the following: bit 7 of the pending, enable and delegate vectors, both global enable bits, the machine group mask and the supervisor group mask. While an interrupt is taken, all debug outputs are 0.
- R8: All outputs are registered and change one clock after the inputs. A synchronous reset clears `take_o` and drives every other output to 0.
- R9: A `priv_i` of 2 or 3 blocks the supervisor group even when that group is enabled and nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pend_i | input | IRQ_W | Pending interrupt bits |
| enbl_i | input | IRQ_W | Per-source enable bits |
| deleg_i | input | IRQ_W | Per-source delegation to supervisor |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| take_o | output | 1 | An interrupt is selected |
| cause_o | output | CAUSE_W | Selected cause code |
| target_o | output | 2 | Privilege receiving the interrupt |
| reason_o | output | 2 | 0 none applies, 1 machine picker empty, 2 supervisor picker empty, 3 taken |
| dbg_tim_pend_o | output | 1 | Machine timer pending bit, when idle |
| dbg_tim_enbl_o | output | 1 | Machine timer enable bit, when idle |
| dbg_tim_deleg_o | output | 1 | Machine timer delegate bit, when idle |
| dbg_m_gie_o | output | 1 | Machine global enable, when idle |
| dbg_s_gie_o | output | 1 | Supervisor global enable, when idle |
| dbg_m_mask_o | output | IRQ_W | Machine group mask, when idle |
| dbg_s_mask_o | output | IRQ_W | Supervisor group mask, when idle |

## Verification
The bench builds the block with the default IRQ_W of 12, which is the narrowest width that holds every standard cause code. At this width bits 0, 2, 4, 6, 8 and 10 are non-standard, which gives the tests access to the empty-picker cases of R6. Setting only those bits makes a group apply while its picker finds nothing. This lets the bench tell the machine-first rule apart from a plain "first group with a winner" rule.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    RSN_NONE    = 2'd0,
    RSN_M_EMPTY = 2'd1,
    RSN_S_EMPTY = 2'd2,
    RSN_TAKEN   = 2'd3
  } reason_e;

  localparam int NPRI      = 6;
  localparam int TIMER_BIT = 7;
  localparam int MIN_W     = 12;

  // Slot k of the priority list, slot 0 is the highest priority.
  function automatic int prio_code(input int k);
    case (k)
      0:       return 11;
      1:       return 3;
      2:       return 7;
      3:       return 9;
      4:       return 1;
      default: return 5;
    endcase
  endfunction

endpackage

// File: rtl/irq_mask_split.sv
module irq_mask_split #(
  parameter int IRQ_W = 12
) (
  input  logic [IRQ_W-1:0] pend_i,
  input  logic [IRQ_W-1:0] enbl_i,
  input  logic [IRQ_W-1:0] deleg_i,
  output logic [IRQ_W-1:0] m_set_o,
  output logic [IRQ_W-1:0] s_set_o
);
  logic [IRQ_W-1:0] live;

  assign live    = pend_i & enbl_i;
  assign m_set_o = live & ~deleg_i;
  assign s_set_o = live & deleg_i;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_sel_pkg::*;
#(
  parameter int IRQ_W   = 12,
  parameter int CAUSE_W = $clog2(IRQ_W)
) (
  input  logic [IRQ_W-1:0]   set_i,
  output logic               found_o,
  output logic [CAUSE_W-1:0] code_o
);
  logic [NPRI-1:0] hit;

  for (genvar k = 0; k < NPRI; k++) begin : g_slot
    assign hit[k] = set_i[prio_code(k)];
  end

  always_comb begin
    found_o = 1'b0;
    code_o  = '0;
    for (int k = NPRI - 1; k >= 0; k--) begin
      if (hit[k]) begin
        found_o = 1'b1;
        code_o  = CAUSE_W'(prio_code(k));
      end
    end
  end
endmodule

// File: rtl/irq_deleg_select.sv
module irq_deleg_select
  import irq_sel_pkg::*;
#(
  parameter int IRQ_W   = 12,
  parameter int CAUSE_W = $clog2(IRQ_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [IRQ_W-1:0]   pend_i,
  input  logic [IRQ_W-1:0]   enbl_i,
  input  logic [IRQ_W-1:0]   deleg_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  input  logic [1:0]         priv_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic [1:0]         target_o,
  output logic [1:0]         reason_o,
  output logic               dbg_tim_pend_o,
  output logic               dbg_tim_enbl_o,
  output logic               dbg_tim_deleg_o,
  output logic               dbg_m_gie_o,
  output logic               dbg_s_gie_o,
  output logic [IRQ_W-1:0]   dbg_m_mask_o,
  output logic [IRQ_W-1:0]   dbg_s_mask_o
);
  logic [IRQ_W-1:0]   m_set, s_set;
  logic               m_found, s_found;
  logic [CAUSE_W-1:0] m_code, s_code;
  logic               m_apply, s_apply, s_priv_ok;

  logic               nx_take;
  logic [CAUSE_W-1:0] nx_cause;
  priv_e              nx_tgt;
  reason_e            nx_rsn;

  irq_mask_split #(.IRQ_W(IRQ_W)) u_split (
    .pend_i (pend_i),
    .enbl_i (enbl_i),
    .deleg_i(deleg_i),
    .m_set_o(m_set),
    .s_set_o(s_set)
  );

  irq_prio_pick #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_pick_m (
    .set_i  (m_set),
    .found_o(m_found),
    .code_o (m_code)
  );

  irq_prio_pick #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_pick_s (
    .set_i  (s_set),
    .found_o(s_found),
    .code_o (s_code)
  );

  assign s_priv_ok = (priv_i == PRIV_U) || (priv_i == PRIV_S);
  assign m_apply   = m_gie_i && (|m_set);
  assign s_apply   = s_gie_i && (|s_set) && s_priv_ok;

  always_comb begin
    nx_take  = 1'b0;
    nx_cause = '0;
    nx_tgt   = PRIV_U;
    nx_rsn   = RSN_NONE;
    if (m_apply) begin
      if (m_found) begin
        nx_take  = 1'b1;
        nx_cause = m_code;
        nx_tgt   = PRIV_M;
        nx_rsn   = RSN_TAKEN;
      end else begin
        nx_rsn = RSN_M_EMPTY;
      end
    end else if (s_apply) begin
      if (s_found) begin
        nx_take  = 1'b1;
        nx_cause = s_code;
        nx_tgt   = PRIV_S;
        nx_rsn   = RSN_TAKEN;
      end else begin
        nx_rsn = RSN_S_EMPTY;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o          <= 1'b0;
      cause_o         <= '0;
      target_o        <= PRIV_U;
      reason_o        <= RSN_NONE;
      dbg_tim_pend_o  <= 1'b0;
      dbg_tim_enbl_o  <= 1'b0;
      dbg_tim_deleg_o <= 1'b0;
      dbg_m_gie_o     <= 1'b0;
      dbg_s_gie_o     <= 1'b0;
      dbg_m_mask_o    <= '0;
      dbg_s_mask_o    <= '0;
    end else begin
      take_o   <= nx_take;
      cause_o  <= nx_cause;
      target_o <= nx_tgt;
      reason_o <= nx_rsn;
      if (nx_take) begin
        dbg_tim_pend_o  <= 1'b0;
        dbg_tim_enbl_o  <= 1'b0;
        dbg_tim_deleg_o <= 1'b0;
        dbg_m_gie_o     <= 1'b0;
        dbg_s_gie_o     <= 1'b0;
        dbg_m_mask_o    <= '0;
        dbg_s_mask_o    <= '0;
      end else begin
        dbg_tim_pend_o  <= pend_i[TIMER_BIT];
        dbg_tim_enbl_o  <= enbl_i[TIMER_BIT];
        dbg_tim_deleg_o <= deleg_i[TIMER_BIT];
        dbg_m_gie_o     <= m_gie_i;
        dbg_s_gie_o     <= s_gie_i;
        dbg_m_mask_o    <= m_set;
        dbg_s_mask_o    <= s_set;
      end
    end
  end
endmodule

// File: rtl/irq_deleg_select_chk.sv
module irq_deleg_select_chk #(
  parameter int IRQ_W   = 12,
  parameter int CAUSE_W = $clog2(IRQ_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [IRQ_W-1:0]   pend_i,
  input logic [IRQ_W-1:0]   enbl_i,
  input logic [IRQ_W-1:0]   deleg_i,
  input logic               m_gie_i,
  input logic               s_gie_i,
  input logic [1:0]         priv_i,
  input logic               take_o,
  input logic [CAUSE_W-1:0] cause_o,
  input logic [1:0]         target_o,
  input logic [1:0]         reason_o,
  input logic [IRQ_W-1:0]   dbg_m_mask_o,
  input logic [IRQ_W-1:0]   dbg_s_mask_o
);
  assert_reset_idle_R8: assert property (@(posedge clk)
    rst |=> (!take_o && reason_o == 2'd0));

  assert_no_gie_no_take_R5: assert property (@(posedge clk) disable iff (rst)
    (!m_gie_i && !s_gie_i) |=> !take_o);

  assert_priv_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (priv_i[1]) |=> !(take_o && target_o == 2'd1));

  assert_machine_first_R3: assert property (@(posedge clk) disable iff (rst)
    (m_gie_i && (|(pend_i & enbl_i & ~deleg_i))) |=> !(take_o && target_o == 2'd1));

  assert_target_legal_R1: assert property (@(posedge clk) disable iff (rst)
    take_o |-> ((target_o == 2'd3 || target_o == 2'd1) && reason_o == 2'd3));

  assert_cause_std_R4: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (cause_o == 1 || cause_o == 3 || cause_o == 5 ||
                cause_o == 7 || cause_o == 9 || cause_o == 11));

  assert_dbg_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (dbg_m_mask_o == '0 && dbg_s_mask_o == '0));
endmodule

bind irq_deleg_select irq_deleg_select_chk #(.IRQ_W(IRQ_W), .CAUSE_W(CAUSE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pend_i      (pend_i),
  .enbl_i      (enbl_i),
  .deleg_i     (deleg_i),
  .m_gie_i     (m_gie_i),
  .s_gie_i     (s_gie_i),
  .priv_i      (priv_i),
  .take_o      (take_o),
  .cause_o     (cause_o),
  .target_o    (target_o),
  .reason_o    (reason_o),
  .dbg_m_mask_o(dbg_m_mask_o),
  .dbg_s_mask_o(dbg_s_mask_o)
);

// File: tb/test_irq_deleg_select.sv
module test_irq_deleg_select;
  localparam int W  = 12;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  pend = '0, enbl = '0, deleg = '0;
  logic          mg = 1'b0, sg = 1'b0;
  logic [1:0]    priv = 2'd3;
  logic          take;
  logic [CW-1:0] cause;
  logic [1:0]    tgt, rsn;
  logic          t_p, t_e, t_d, d_mg, d_sg;
  logic [W-1:0]  d_mm, d_sm;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_deleg_select #(.IRQ_W(W)) i_irq_deleg_select (
    .clk(clk), .rst(rst), .pend_i(pend), .enbl_i(enbl), .deleg_i(deleg),
    .m_gie_i(mg), .s_gie_i(sg), .priv_i(priv),
    .take_o(take), .cause_o(cause), .target_o(tgt), .reason_o(rsn),
    .dbg_tim_pend_o(t_p), .dbg_tim_enbl_o(t_e), .dbg_tim_deleg_o(t_d),
    .dbg_m_gie_o(d_mg), .dbg_s_gie_o(d_sg),
    .dbg_m_mask_o(d_mm), .dbg_s_mask_o(d_sm)
  );

  typedef struct packed {
    logic [11:0] pend, enbl, deleg;
    logic        mg, sg;
    logic [1:0]  priv;
    logic        take;
    logic [3:0]  cause;
    logic [1:0]  tgt, rsn;
  } vec_t;

  // Expected results come from R1..R6, R9.
  localparam vec_t TBL [14] = '{
    '{12'h888, 12'hFFF, 12'h000, 1'b1, 1'b0, 2'd3, 1'b1, 4'd11, 2'd3, 2'd3}, // R1 R4
    '{12'h088, 12'hFFF, 12'h000, 1'b1, 1'b0, 2'd3, 1'b1, 4'd3,  2'd3, 2'd3}, // R4
    '{12'h080, 12'h080, 12'h000, 1'b1, 1'b0, 2'd3, 1'b1, 4'd7,  2'd3, 2'd3}, // R1
    '{12'h222, 12'hFFF, 12'h222, 1'b1, 1'b1, 2'd1, 1'b1, 4'd9,  2'd1, 2'd3}, // R2 R4
    '{12'h022, 12'hFFF, 12'h022, 1'b0, 1'b1, 2'd0, 1'b1, 4'd1,  2'd1, 2'd3}, // R2 R4
    '{12'h020, 12'hFFF, 12'h020, 1'b0, 1'b1, 2'd0, 1'b1, 4'd5,  2'd1, 2'd3}, // R2
    '{12'h222, 12'hFFF, 12'h222, 1'b1, 1'b1, 2'd3, 1'b0, 4'd0,  2'd0, 2'd0}, // R9
    '{12'h800, 12'h000, 12'h000, 1'b1, 1'b1, 2'd1, 1'b0, 4'd0,  2'd0, 2'd0}, // R5
    '{12'hA00, 12'hFFF, 12'h200, 1'b1, 1'b1, 2'd1, 1'b1, 4'd11, 2'd3, 2'd3}, // R3
    '{12'h006, 12'hFFF, 12'h002, 1'b1, 1'b1, 2'd1, 1'b0, 4'd0,  2'd0, 2'd1}, // R6 R3
    '{12'h001, 12'hFFF, 12'h001, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0,  2'd0, 2'd2}, // R6
    '{12'h800, 12'hFFF, 12'h000, 1'b0, 1'b1, 2'd1, 1'b0, 4'd0,  2'd0, 2'd0}, // R5
    '{12'h802, 12'hFFF, 12'h002, 1'b0, 1'b1, 2'd1, 1'b1, 4'd1,  2'd1, 2'd3}, // R2
    '{12'h022, 12'hFFF, 12'h022, 1'b0, 1'b1, 2'd2, 1'b0, 4'd0,  2'd0, 2'd0}  // R9
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    pend = v.pend; enbl = v.enbl; deleg = v.deleg;
    mg = v.mg; sg = v.sg; priv = v.priv;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 take after reset", int'(take), 0);
    chk("R8 reason after reset", int'(rsn), 0);
    chk("R8 dbg mask after reset", int'(d_mm | d_sm), 0);
    rst = 1'b0;

    for (int i = 0; i < 14; i++) begin
      drive(TBL[i]);
      @(negedge clk);
      chk($sformatf("R1/R2 vec %0d take", i), int'(take), int'(TBL[i].take));
      chk($sformatf("R4 vec %0d cause", i), int'(cause), int'(TBL[i].cause));
      chk($sformatf("R1/R2 vec %0d target", i), int'(tgt), int'(TBL[i].tgt));
      chk($sformatf("R5/R6 vec %0d reason", i), int'(rsn), int'(TBL[i].rsn));
    end

    // R7: debug content while idle (supervisor blocked by priv 3)
    drive(TBL[6]);
    @(negedge clk);
    chk("R7 tim pend", int'(t_p), 0);
    chk("R7 tim enbl", int'(t_e), 1);
    chk("R7 tim deleg", int'(t_d), 0);
    chk("R7 m gie", int'(d_mg), 1);
    chk("R7 s gie", int'(d_sg), 1);
    chk("R7 m mask", int'(d_mm), 'h000);
    chk("R7 s mask", int'(d_sm), 'h222);

    // R7: timer bits all set, delegated, no global enables
    pend = 12'h080; enbl = 12'h080; deleg = 12'h080; mg = 0; sg = 0; priv = 2'd1;
    @(negedge clk);
    chk("R7 idle take", int'(take), 0);
    chk("R7 tim bits", int'({t_p, t_e, t_d}), 7);
    chk("R7 gies", int'({d_mg, d_sg}), 0);
    chk("R7 s mask timer", int'(d_sm), 'h080);
    chk("R7 m mask timer", int'(d_mm), 0);

    // R7: debug quiet when taken; R8: one-cycle latency
    drive(TBL[0]);
    #1;
    chk("R8 output held before edge", int'(take), 0);
    @(negedge clk);
    chk("R8 take after edge", int'(take), 1);
    chk("R7 dbg zero when taken", int'({t_p, t_e, t_d, d_mg, d_sg}), 0);
    chk("R7 masks zero when taken", int'(d_mm | d_sm), 0);

    // R8: synchronous reset clears while inputs still request
    rst = 1'b1;
    @(negedge clk);
    chk("R8 reset clears take", int'(take), 0);
    chk("R8 reset clears cause", int'(cause), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 resumes after reset", int'(cause), 11);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule